// File: doc/BRIEF.md
# Four-Stage Pipelined SHA-1 Compression Engine

This block runs the SHA-1 compression function on 512-bit message blocks, with up to four independent blocks in flight at once. The 80 rounds are split across four stages of 20 rounds each. Inside a stage, every clock computes two rounds, and a running temporary (`e + W + K` for the next round) is precomputed so that the critical path holds only one round function and two adders. The first stage spends one extra cycle on that precomputation and then runs ten double-round cycles. The other stages run ten double-round cycles and then wait for one cycle.

All stages hand their work forward together on a common boundary every 11 cycles. A new block can enter only on that boundary. Each accepted block carries its own 160-bit input chaining value and a small group tag. These travel through side FIFOs, which keeps the per-stage registers free of them. When a block leaves the last stage, its chaining value is added word by word to the final working state. The digest then appears with the block's tag for exactly one cycle. Message padding and the choice of chaining value belong to the surrounding logic.

Top module: `sha1_quad_pipe`

## Requirements
- R1: `out_digest` equals the SHA-1 compression of `in_block` under `in_chain`, with the chaining value added word-wise. Word 0 of the block sits at bits [511:480], and chaining word H0 sits at bits [159:128] of both `in_chain` and `out_digest`.
- R2: `in_ready` is high for exactly one cycle in every 11. Counting rising edges after reset is released as 1, 2, 3 and so on, it is high after edge n exactly when n mod 11 equals 10.
- R3: A block accepted on a rising edge (`in_valid` and `in_ready` both high) yields `out_valid` high after the rising edge 44 cycles later.
- R4: `out_valid` is a single-cycle pulse, given once per accepted block.
- R5: Digests leave in the order the blocks were accepted, and each carries the `in_tag` given with its block on `out_tag`.
- R6: A block can be accepted at every ready cycle, with no stall. Four blocks are then in flight and each still meets R1, R3 and R5.
- R7: A ready cycle with `in_valid` low leaves a bubble. No output appears 44 cycles later, and the digests and tags of the blocks around it are unaffected.
- R8: `in_valid` while `in_ready` is low is ignored. It produces no output and does not disturb any other block's digest or tag.
- R9: While `rst` is high, `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Engine takes a block on this cycle's edge |
| in_block | input | 512 | Message block, word 0 in the top bits |
| in_chain | input | 160 | Input chaining value, H0 in the top bits |
| in_tag | input | TAG_W (2) | Message-group tag |
| out_valid | output | 1 | Digest valid for one cycle |
| out_digest | output | 160 | Resulting chaining value |
| out_tag | output | TAG_W (2) | Tag of the block that produced the digest |

## Verification
On every boundary edge of a full pipeline, two things happen on the same rising edge. The oldest block leaves, which pops both side FIFOs and registers its digest. A new block enters, which pushes its chaining value and tag. The bench provokes this by feeding blocks at every ready slot with distinct chaining values and rotating tags. A cycle-accurate model then confirms that every digest pairs with its own chaining value and tag, and that no entry is lost or duplicated. Bubbles and off-slot `in_valid` pulses are mixed into the same stream, so that pushes and pops on shared edges are judged with uneven FIFO occupancy.

// File: rtl/sha1_pipe_pkg.sv
package sha1_pipe_pkg;

  localparam int SHA_ROUNDS = 80;
  localparam int WORD_W     = 32;
  localparam int BLOCK_W    = 512;
  localparam int CHAIN_W    = 160;

  // working words plus the precomputed pre-add for the next round
  typedef struct packed {
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] c;
    logic [WORD_W-1:0] d;
    logic [WORD_W-1:0] e;
    logic [WORD_W-1:0] p;
  } sha1_state_t;

  function automatic logic [31:0] rol(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] round_fn(input logic [7:0] t, input logic [31:0] x,
                                           input logic [31:0] y, input logic [31:0] z);
    if (t < 8'd20)      return (x & y) | (~x & z);
    else if (t < 8'd40) return x ^ y ^ z;
    else if (t < 8'd60) return (x & y) | (x & z) | (y & z);
    else                return x ^ y ^ z;
  endfunction

  function automatic logic [31:0] round_const(input logic [7:0] t);
    if (t < 8'd20)      return 32'h5A827999;
    else if (t < 8'd40) return 32'h6ED9EBA1;
    else if (t < 8'd60) return 32'h8F1BBCDC;
    else                return 32'hCA62C1D6;
  endfunction

  function automatic logic [31:0] word_at(input logic [511:0] v, input int i);
    return v[511-32*i -: 32];
  endfunction

endpackage

// File: rtl/sha1_dbl_round.sv
module sha1_dbl_round
  import sha1_pipe_pkg::*;
(
  input  logic [7:0]         step,
  input  sha1_state_t        st,
  input  logic [BLOCK_W-1:0] win,
  output sha1_state_t        st_n,
  output logic [BLOCK_W-1:0] win_n
);

  logic [31:0] w0, w1, w2, w3, w8, w9, w13, w14;
  logic [31:0] a_mid, n16, n17;
  logic [7:0]  step1, step2;

  always_comb begin
    w0  = word_at(win, 0);
    w1  = word_at(win, 1);
    w2  = word_at(win, 2);
    w3  = word_at(win, 3);
    w8  = word_at(win, 8);
    w9  = word_at(win, 9);
    w13 = word_at(win, 13);
    w14 = word_at(win, 14);
    step1 = step + 8'd1;
    step2 = step + 8'd2;

    // first round: pre-add already holds e + W + K
    a_mid = rol(st.a, 5) + round_fn(step, st.b, st.c, st.d) + st.p;

    // second round works from the same registered words
    st_n.a = rol(a_mid, 5) + round_fn(step1, st.a, rol(st.b, 30), st.c)
             + st.d + w1 + round_const(step1);
    st_n.b = a_mid;
    st_n.c = rol(st.a, 30);
    st_n.d = rol(st.b, 30);
    st_n.e = st.c;
    st_n.p = st.c + w2 + round_const(step2);

    // schedule window slides by two words
    n16   = rol(w13 ^ w8 ^ w2 ^ w0, 1);
    n17   = rol(w14 ^ w9 ^ w3 ^ w1, 1);
    win_n = {win[BLOCK_W-65:0], n16, n17};
  end

endmodule

// File: rtl/sha1_pipe_stage.sv
module sha1_pipe_stage
  import sha1_pipe_pkg::*;
#(
  parameter int STAGE      = 0,
  parameter int NUM_STAGES = 4,
  parameter int PH_W       = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PH_W-1:0]    phase,
  input  logic               advance,
  input  logic               up_valid,
  input  sha1_state_t        up_st,
  input  logic [BLOCK_W-1:0] up_win,
  output logic               cur_valid,
  output sha1_state_t        nxt_st,
  output logic [BLOCK_W-1:0] nxt_win
);

  localparam int SPS    = SHA_ROUNDS / NUM_STAGES;
  localparam int PERIOD = SPS / 2 + 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  sha1_state_t        st_q, rnd_st;
  logic [BLOCK_W-1:0] win_q, rnd_win;
  logic               vld_q;
  logic               pre_cyc, dbl_cyc;
  logic [PH_W-1:0]    jidx;
  logic [7:0]         step;

  generate
    if (STAGE == 0) begin : g_head
      // one precompute cycle, then double rounds through the boundary
      assign pre_cyc = (phase == '0);
      assign dbl_cyc = (phase != '0);
      assign jidx    = phase - PH_W'(1);
    end else begin : g_body
      // double rounds first, idle on the boundary cycle
      assign pre_cyc = 1'b0;
      assign dbl_cyc = (phase != LAST);
      assign jidx    = phase;
    end
  endgenerate

  assign step = 8'(STAGE * SPS) + {jidx[PH_W-2:0], 1'b0};

  sha1_dbl_round u_round (
    .step  (step),
    .st    (st_q),
    .win   (win_q),
    .st_n  (rnd_st),
    .win_n (rnd_win)
  );

  always_comb begin
    nxt_st  = st_q;
    nxt_win = win_q;
    if (pre_cyc) begin
      nxt_st.p = st_q.e + word_at(win_q, 0) + round_const(8'(STAGE * SPS));
    end else if (dbl_cyc) begin
      nxt_st  = rnd_st;
      nxt_win = rnd_win;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          vld_q <= 1'b0;
    else if (advance) vld_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      st_q  <= up_st;
      win_q <= up_win;
    end else begin
      st_q  <= nxt_st;
      win_q <= nxt_win;
    end
  end

  assign cur_valid = vld_q;

  // R7
  stage_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !up_valid) |=> !cur_valid);

endmodule

// File: rtl/sha1_side_fifo.sv
module sha1_side_fifo #(
  parameter int WIDTH = 160,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] ptr);
    return (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assign rd_data = mem[rd_ptr];

  // R6
  fifo_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> (count < CW'(DEPTH)));

  // R5
  fifo_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

endmodule

// File: rtl/sha1_quad_pipe.sv
module sha1_quad_pipe
  import sha1_pipe_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int TAG_W      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [BLOCK_W-1:0] in_block,
  input  logic [CHAIN_W-1:0] in_chain,
  input  logic [TAG_W-1:0]   in_tag,
  output logic               out_valid,
  output logic [CHAIN_W-1:0] out_digest,
  output logic [TAG_W-1:0]   out_tag
);

  localparam int SPS    = SHA_ROUNDS / NUM_STAGES;
  localparam int PERIOD = SPS / 2 + 1;
  localparam int PH_W   = $clog2(PERIOD) + 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phase, phase_n;
  logic            advance, in_fire, ready_q, tail_vld;

  logic               lane_vld [NUM_STAGES];
  sha1_state_t        lane_st  [NUM_STAGES];
  logic [BLOCK_W-1:0] lane_win [NUM_STAGES];
  sha1_state_t        head_st;
  sha1_state_t        tail_st;
  logic [CHAIN_W-1:0] fifo_chain;
  logic [TAG_W-1:0]   fifo_tag;

  assign advance = (phase == LAST);
  assign phase_n = advance ? '0 : phase + PH_W'(1);
  assign in_fire = in_valid && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      ready_q <= 1'b0;
    end else begin
      phase   <= phase_n;
      ready_q <= (phase_n == LAST);
    end
  end

  assign in_ready = ready_q;

  always_comb begin
    head_st.a = in_chain[159:128];
    head_st.b = in_chain[127:96];
    head_st.c = in_chain[95:64];
    head_st.d = in_chain[63:32];
    head_st.e = in_chain[31:0];
    head_st.p = '0;
  end

  generate
    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_src_in
        sha1_pipe_stage #(.STAGE(s), .NUM_STAGES(NUM_STAGES), .PH_W(PH_W)) u_stage (
          .clk       (clk),
          .rst       (rst),
          .phase     (phase),
          .advance   (advance),
          .up_valid  (in_fire),
          .up_st     (head_st),
          .up_win    (in_block),
          .cur_valid (lane_vld[s]),
          .nxt_st    (lane_st[s]),
          .nxt_win   (lane_win[s])
        );
      end else begin : g_src_prev
        sha1_pipe_stage #(.STAGE(s), .NUM_STAGES(NUM_STAGES), .PH_W(PH_W)) u_stage (
          .clk       (clk),
          .rst       (rst),
          .phase     (phase),
          .advance   (advance),
          .up_valid  (lane_vld[s-1]),
          .up_st     (lane_st[s-1]),
          .up_win    (lane_win[s-1]),
          .cur_valid (lane_vld[s]),
          .nxt_st    (lane_st[s]),
          .nxt_win   (lane_win[s])
        );
      end
    end
  endgenerate

  assign tail_vld = lane_vld[NUM_STAGES-1];
  assign tail_st  = lane_st[NUM_STAGES-1];

  sha1_side_fifo #(.WIDTH(CHAIN_W), .DEPTH(NUM_STAGES)) u_chain_fifo (
    .clk     (clk),
    .rst     (rst),
    .push    (in_fire),
    .wr_data (in_chain),
    .pop     (advance && tail_vld),
    .rd_data (fifo_chain)
  );

  sha1_side_fifo #(.WIDTH(TAG_W), .DEPTH(NUM_STAGES)) u_tag_fifo (
    .clk     (clk),
    .rst     (rst),
    .push    (in_fire),
    .wr_data (in_tag),
    .pop     (advance && tail_vld),
    .rd_data (fifo_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= advance && tail_vld;
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      out_digest <= {tail_st.a + fifo_chain[159:128],
                     tail_st.b + fifo_chain[127:96],
                     tail_st.c + fifo_chain[95:64],
                     tail_st.d + fifo_chain[63:32],
                     tail_st.e + fifo_chain[31:0]};
      out_tag    <= fifo_tag;
    end
  end

  // R4
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R2
  ready_gap_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);

  // R7
  out_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(tail_vld));

endmodule

// File: tb/sha1_quad_pipe_tb.sv
`timescale 1ns/1ps
module sha1_quad_pipe_tb_top;

  localparam int PERIOD = 11;
  localparam int LAT    = 44;
  localparam int RUN    = 260;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] in_block = '0;
  logic [159:0] in_chain = '0;
  logic [1:0]   in_tag = '0;
  logic         out_valid;
  logic [159:0] out_digest;
  logic [1:0]   out_tag;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  typedef struct {
    int           due;
    logic [159:0] dig;
    logic [1:0]   tag;
    string        req;
  } exp_t;
  exp_t q[$];

  localparam logic [159:0] STD_IV  = 160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;
  localparam logic [159:0] ABC_DIG = 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d;

  always #4 clk = ~clk;

  sha1_quad_pipe dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .in_chain(in_chain), .in_tag(in_tag),
    .out_valid(out_valid), .out_digest(out_digest), .out_tag(out_tag)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_hash(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = m[511-32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [511:0] rand_block();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [159:0] got, input logic [159:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  initial begin
    exp_t e;
    int   slot;
    logic [511:0] blk;
    logic [159:0] iv;
    // R9: reset state
    repeat (4) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R9", "in_ready in reset", 160'(in_ready), 160'd0);
      chk(out_valid == 1'b0, "R9", "out_valid in reset", 160'(out_valid), 160'd0);
    end
    rst = 1'b0;
    for (int cyc = 1; cyc <= RUN; cyc++) begin
      bit exp_ready, exp_out;
      @(negedge clk);
      exp_ready = (cyc % PERIOD == PERIOD - 1);
      // R2: ready cadence
      chk(in_ready == exp_ready, "R2", "in_ready cadence", 160'(in_ready), 160'(exp_ready));
      exp_out = (q.size() > 0) && (q[0].due == cyc);
      // R3 R4 R7 R8: pulse position and absence
      chk(out_valid == exp_out, "R3/R4/R7/R8", "out_valid", 160'(out_valid), 160'(exp_out));
      if (exp_out) begin
        e = q.pop_front();
        chk(out_digest == e.dig, e.req, "digest (R1)", out_digest, e.dig);
        chk(out_tag == e.tag, "R5", "tag order", 160'(out_tag), 160'(e.tag));
      end
      // drive for the next edge
      in_valid = 1'b0;
      in_block = '0;
      in_chain = '0;
      in_tag   = '0;
      if (exp_ready) begin
        slot = cyc / PERIOD;
        if (slot == 0) begin
          // R1: known single-block vector
          blk = '0;
          blk[511:480] = 32'h61626380;
          blk[31:0]    = 32'h00000018;
          in_valid = 1'b1; in_block = blk; in_chain = STD_IV; in_tag = 2'd1;
          e.due = cyc + 1 + LAT; e.dig = ABC_DIG; e.tag = 2'd1; e.req = "R1";
          q.push_back(e);
        end else if (slot <= 8 || (slot <= 14 && (slot % 2 == 1))) begin
          // R6: every slot filled; R7: alternate slots left empty
          blk = rand_block();
          iv  = {$urandom, $urandom, $urandom, $urandom, $urandom};
          in_valid = 1'b1; in_block = blk; in_chain = iv; in_tag = 2'(slot);
          e.due = cyc + 1 + LAT; e.dig = ref_hash(iv, blk); e.tag = 2'(slot);
          e.req = (slot <= 8) ? "R6" : "R7";
          q.push_back(e);
        end
      end else if (cyc >= 100 && cyc < 200) begin
        // R8: off-slot junk
        in_valid = 1'b1;
        in_block = rand_block();
        in_chain = {$urandom, $urandom, $urandom, $urandom, $urandom};
        in_tag   = 2'(cyc);
      end
    end
    chk(q.size() == 0, "R3", "outstanding digests", 160'(q.size()), 160'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R3 watchdog: got running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule